// File: doc/BRIEF.md
# Ring Buffer Controller for a Shared Word Memory

This block runs one circular queue whose storage lives in a word-addressed SRAM that other logic also uses. One 32-bit packed word sets it up at run time: where the ring starts in memory, how many words the ring holds, how many words make one entry, the two watermark codes, and the starting read and write offsets. A single-cycle load strobe takes the whole word in at once.

After it is loaded, the block accepts push and pop strobes of one entry each. For every accepted operation it produces one memory access per word of the entry, on consecutive cycles. Each access carries the physical word address, a write or read enable and the index of the word within the entry. The SRAM and its data path stay outside the block; the block supplies only addresses and enables.

The block counts occupancy in entries. From that count it drives empty, full, nearly-empty and nearly-full flags. A push refused because the queue is full, or a pop refused because it is empty, has no effect on the queue and raises a one-cycle error pulse.

Top module: `sram_queue_ctrl`

## Requirements
- R1: The ring length follows the 2-bit size code: 00 gives 16 words, 01 gives 32, 10 gives 64 and 11 gives 128. Both offsets wrap modulo that length.
- R2: The entry length follows the 2-bit entry code: 00 gives 1 word, 01 gives 2, 10 gives 4, and 11 is treated as 1. An accepted operation makes exactly that many accesses on back-to-back cycles, with `word_idx` counting 0, 1 and so on.
- R3: The address of each access is base×16 + ((starting offset + word index) mod ring length). A push starts at the write offset and a pop starts at the read offset, so the words come back out in the order they went in.
- R4: A push or pop strobe is taken at a rising edge where `ready` is high. Its first access appears in the cycle after that edge. `ready` stays low until the cycle after the last word. The offset in use then advances by the entry length.
- R5: Occupancy is counted in entries. Capacity is the ring length divided by the entry length. `empty` is high at occupancy 0, `full` is high at capacity, and the two are never high together. Both update in the cycle after the accepting edge.
- R6: A push taken while `full` is high is ignored. It writes nothing and changes no state, and `err_overflow` is high for the following cycle.
- R7: A pop taken while `empty` is high is ignored. It reads nothing and changes no state, and `err_underflow` is high for the following cycle.
- R8: `nearly_empty` is high when occupancy ≤ the low threshold. A 3-bit code c gives a threshold of 0 entries for c=0 and 2^(c−1) entries otherwise, so 1, 2, 4, 8, 16, 32 and 64 for codes 1 to 7. A code is only meaningful when its threshold is below the ring length.
- R9: `nearly_full` is high when (capacity − occupancy) ≤ the high threshold. The high threshold uses the same code mapping as R8.
- R10: If push and pop are both presented to a ready block, the push is served and the pop is dropped without an error.
- R11: `cfg_load` writes the configuration word. Its fields are: bits 6:0 the write offset, 13:7 the read offset, 21:14 the base in 16-word units, 23:22 the entry code, 25:24 the size code, 28:26 the low watermark code, and 31:29 the high watermark code. The offsets are taken modulo the ring length. Occupancy becomes ((write − read) mod ring length) / entry length. A load ends any access sequence in progress, and push and pop are not considered in that cycle.
- R12: After reset the configuration is all zeros: a 16-word ring, 1-word entries, base 0 and both thresholds 0. Occupancy is 0, so `empty` and `nearly_empty` are high, `full` and `nearly_full` are low, `ready` is high, and no access or error is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load strobe for `cfg_word` |
| cfg_word | input | 32 | Packed configuration word |
| push_req | input | 1 | Push one entry |
| pop_req | input | 1 | Pop one entry |
| ready | output | 1 | High when a new push or pop can be taken |
| mem_addr | output | 13 | Physical SRAM word address of the current access |
| mem_we | output | 1 | Write enable for the current access |
| mem_re | output | 1 | Read enable for the current access |
| word_idx | output | 2 | Index of the current word within its entry |
| empty | output | 1 | Occupancy is zero |
| full | output | 1 | Occupancy equals capacity |
| nearly_empty | output | 1 | Occupancy at or below the low threshold |
| nearly_full | output | 1 | Free entries at or below the high threshold |
| err_overflow | output | 1 | One-cycle pulse after a refused push |
| err_underflow | output | 1 | One-cycle pulse after a refused pop |

## Verification
The directed part fills a 16-word ring of single-word entries, using the aliased entry code, until it is full. It then pushes past full, presents push and pop together both while full and while not full, and drains the ring back through the wrap point. This separates correct full/empty detection and push priority from an off-by-one in capacity or in the wrap. A load with unequal starting offsets and 2-word entries shows whether occupancy is derived from the offset difference or simply cleared. A 128-word ring of 4-word entries exercises the largest size and the longest access burst. The random part then loads several aligned configurations, with bases and offsets drawn from a fixed seed, and runs mixed push/pop traffic with a changing bias. There every address is checked against the formula and every popped word against the word pushed in that position, which exposes address, ordering and watermark errors that only appear at particular occupancies.

// File: rtl/qc_pkg.sv
package qc_pkg;

   // entry-length codes; the fourth value falls back to one word
   typedef enum logic [1:0] {
      ENT_ONE   = 2'b00,
      ENT_TWO   = 2'b01,
      ENT_FOUR  = 2'b10,
      ENT_ALIAS = 2'b11
   } ent_code_e;

   typedef enum logic {
      OP_READ  = 1'b0,
      OP_WRITE = 1'b1
   } op_e;

   // log2 of the entry length in words
   function automatic logic [1:0] ent_shift(input logic [1:0] code);
      logic [1:0] sh;
      case (ent_code_e'(code))
         ENT_TWO:  sh = 2'd1;
         ENT_FOUR: sh = 2'd2;
         default:  sh = 2'd0;
      endcase
      return sh;
   endfunction

endpackage

// File: rtl/qc_cfg_decode.sv
module qc_cfg_decode #(
   parameter int PTR_W    = 7,
   parameter int BLK_LOG2 = 4,
   parameter int RING_W   = 2,
   parameter int WM_W     = 3,
   localparam int CNT_W   = PTR_W + 1
) (
   input  logic [RING_W-1:0] ring_code,
   input  logic [1:0]        ent_code,
   input  logic [WM_W-1:0]   hi_code,
   input  logic [WM_W-1:0]   lo_code,
   output logic [PTR_W-1:0]  ring_mask,
   output logic [2:0]        ent_words,
   output logic [CNT_W-1:0]  cap,
   output logic [CNT_W-1:0]  hi_thr,
   output logic [CNT_W-1:0]  lo_thr
);

   localparam int N_WM     = 1 << WM_W;
   localparam int MAX_RING = (1 << BLK_LOG2) << ((1 << RING_W) - 1);

   if (MAX_RING > (1 << PTR_W)) begin : g_bad_ring
      $error("qc_cfg_decode: largest ring does not fit the offset width");
   end
   if ((N_WM - 2) >= CNT_W) begin : g_bad_wm
      $error("qc_cfg_decode: largest watermark does not fit the count width");
   end

   // logarithmic watermark table: 0, then powers of two
   logic [CNT_W-1:0] thr_lut [N_WM];

   for (genvar g = 0; g < N_WM; g++) begin : g_thr
      if (g == 0) begin : g_zero
         assign thr_lut[g] = '0;
      end else begin : g_pow
         assign thr_lut[g] = CNT_W'(1) << (g - 1);
      end
   end

   logic [CNT_W-1:0] ring_words;
   logic [1:0]       ent_log;

   always_comb begin
      ent_log    = qc_pkg::ent_shift(ent_code);
      ent_words  = 3'd1 << ent_log;
      ring_words = CNT_W'(1 << BLK_LOG2) << ring_code;
      ring_mask  = PTR_W'(ring_words - CNT_W'(1));
      cap        = ring_words >> ent_log;
      hi_thr     = thr_lut[hi_code];
      lo_thr     = thr_lut[lo_code];
   end

endmodule

// File: rtl/qc_occupancy.sv
module qc_occupancy #(
   parameter int PTR_W    = 7,
   parameter int BLK_LOG2 = 4,
   parameter int RING_W   = 2,
   localparam int CNT_W   = PTR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [PTR_W-1:0]  ld_rd,
   input  logic [PTR_W-1:0]  ld_wr,
   input  logic [RING_W-1:0] ld_ring_code,
   input  logic [1:0]        ld_ent_code,
   input  logic              push_try,
   input  logic              pop_try,
   input  logic [PTR_W-1:0]  ring_mask,
   input  logic [2:0]        ent_words,
   input  logic [CNT_W-1:0]  cap,
   input  logic [CNT_W-1:0]  hi_thr,
   input  logic [CNT_W-1:0]  lo_thr,
   output logic [PTR_W-1:0]  rd_ptr,
   output logic [PTR_W-1:0]  wr_ptr,
   output logic              acc_push,
   output logic              acc_pop,
   output logic              empty,
   output logic              full,
   output logic              near_empty,
   output logic              near_full,
   output logic              err_ovf,
   output logic              err_udf
);

   logic [CNT_W-1:0] count_q;
   logic [PTR_W-1:0] rd_q, wr_q;
   logic [PTR_W-1:0] ld_mask, ld_span, step;
   logic [1:0]       ld_sh;

   always_comb begin
      ld_mask    = PTR_W'((CNT_W'(1 << BLK_LOG2) << ld_ring_code) - CNT_W'(1));
      ld_sh      = qc_pkg::ent_shift(ld_ent_code);
      ld_span    = (ld_wr - ld_rd) & ld_mask;
      step       = PTR_W'(ent_words);
      empty      = (count_q == '0);
      full       = (count_q == cap);
      near_empty = (count_q <= lo_thr);
      near_full  = ((cap - count_q) <= hi_thr);
      acc_push   = push_try & ~full;
      acc_pop    = pop_try & ~empty;
      rd_ptr     = rd_q;
      wr_ptr     = wr_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q    <= '0;
         wr_q    <= '0;
         count_q <= '0;
         err_ovf <= 1'b0;
         err_udf <= 1'b0;
      end else begin
         err_ovf <= push_try & full;
         err_udf <= pop_try & empty;
         if (load) begin
            rd_q    <= ld_rd & ld_mask;
            wr_q    <= ld_wr & ld_mask;
            count_q <= CNT_W'(ld_span >> ld_sh);
         end else if (acc_push) begin
            wr_q    <= (wr_q + step) & ring_mask;
            count_q <= count_q + CNT_W'(1);
         end else if (acc_pop) begin
            rd_q    <= (rd_q + step) & ring_mask;
            count_q <= count_q - CNT_W'(1);
         end
      end
   end

   // R5: occupancy never passes capacity
   p_cnt_cap_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= cap);

   // R4: an accepted push leaves the queue non-empty, an accepted pop leaves it non-full
   p_push_nonempty_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(acc_push)) |-> !empty);
   p_pop_notfull_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(acc_pop)) |-> !full);

   // R6 / R7: a refused request leaves state alone
   p_ovf_hold_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      err_ovf |-> ($stable(count_q) && $stable(wr_q)));
   p_udf_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      err_udf |-> ($stable(count_q) && $stable(rd_q)));

endmodule

// File: rtl/qc_word_seq.sv
module qc_word_seq #(
   parameter int PTR_W    = 7,
   parameter int BASE_W   = 8,
   parameter int BLK_LOG2 = 4,
   localparam int ADDR_W  = BASE_W + BLK_LOG2 + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cancel,
   input  logic              start,
   input  logic              start_wr,
   input  logic [PTR_W-1:0]  start_off,
   input  logic [PTR_W-1:0]  ring_mask,
   input  logic [BASE_W-1:0] base,
   input  logic [2:0]        ent_words,
   output logic              busy,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic              mem_re,
   output logic [1:0]        word_idx
);

   qc_pkg::op_e      op_q;
   logic             busy_q;
   logic [PTR_W-1:0] off_q, word_off;
   logic [1:0]       idx_q, last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         op_q   <= qc_pkg::OP_READ;
         off_q  <= '0;
         idx_q  <= '0;
         last_q <= '0;
      end else if (cancel) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         op_q   <= start_wr ? qc_pkg::OP_WRITE : qc_pkg::OP_READ;
         off_q  <= start_off;
         idx_q  <= '0;
         last_q <= 2'(ent_words - 3'd1);
      end else if (busy_q) begin
         if (idx_q == last_q) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
         end else begin
            idx_q <= idx_q + 2'd1;
         end
      end
   end

   always_comb begin
      word_off = (off_q + PTR_W'(idx_q)) & ring_mask;
      mem_addr = ADDR_W'({base, {BLK_LOG2{1'b0}}}) + ADDR_W'(word_off);
      mem_we   = busy_q && (op_q == qc_pkg::OP_WRITE);
      mem_re   = busy_q && (op_q == qc_pkg::OP_READ);
      busy     = busy_q;
      word_idx = idx_q;
   end

   // R4: no new operation is launched on top of a running one
   p_no_restart_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy_q);
   // R2: word index stays inside the entry
   p_idx_bound_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (idx_q <= last_q));
   // R3: every burst begins at word 0 of the entry
   p_first_idx_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> (idx_q == 2'd0));

endmodule

// File: rtl/sram_queue_ctrl.sv
module sram_queue_ctrl #(
   parameter int PTR_W    = 7,
   parameter int BASE_W   = 8,
   parameter int BLK_LOG2 = 4,
   parameter int RING_W   = 2,
   parameter int WM_W     = 3,
   parameter int CFG_W    = 32,
   localparam int ADDR_W  = BASE_W + BLK_LOG2 + 1,
   localparam int CNT_W   = PTR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_load,
   input  logic [CFG_W-1:0]  cfg_word,
   input  logic              push_req,
   input  logic              pop_req,
   output logic              ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic              mem_re,
   output logic [1:0]        word_idx,
   output logic              empty,
   output logic              full,
   output logic              nearly_empty,
   output logic              nearly_full,
   output logic              err_overflow,
   output logic              err_underflow
);

   // field positions inside the configuration word
   localparam int WR_LSB   = 0;
   localparam int RD_LSB   = WR_LSB + PTR_W;
   localparam int BASE_LSB = RD_LSB + PTR_W;
   localparam int ENT_LSB  = BASE_LSB + BASE_W;
   localparam int RING_LSB = ENT_LSB + 2;
   localparam int LO_LSB   = RING_LSB + RING_W;
   localparam int HI_LSB   = LO_LSB + WM_W;

   if (HI_LSB + WM_W != CFG_W) begin : g_bad_layout
      $error("sram_queue_ctrl: configuration fields do not fill the word");
   end

   logic [WM_W-1:0]   hi_code_q, lo_code_q;
   logic [RING_W-1:0] ring_code_q;
   logic [1:0]        ent_code_q;
   logic [BASE_W-1:0] base_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_code_q   <= '0;
         lo_code_q   <= '0;
         ring_code_q <= '0;
         ent_code_q  <= '0;
         base_q      <= '0;
      end else if (cfg_load) begin
         hi_code_q   <= cfg_word[HI_LSB +: WM_W];
         lo_code_q   <= cfg_word[LO_LSB +: WM_W];
         ring_code_q <= cfg_word[RING_LSB +: RING_W];
         ent_code_q  <= cfg_word[ENT_LSB +: 2];
         base_q      <= cfg_word[BASE_LSB +: BASE_W];
      end
   end

   logic [PTR_W-1:0] ring_mask, rd_ptr, wr_ptr;
   logic [2:0]       ent_words;
   logic [CNT_W-1:0] cap, hi_thr, lo_thr;
   logic             busy, push_try, pop_try, acc_push, acc_pop;

   qc_cfg_decode #(
      .PTR_W(PTR_W), .BLK_LOG2(BLK_LOG2), .RING_W(RING_W), .WM_W(WM_W)
   ) u_dec (
      .ring_code (ring_code_q),
      .ent_code  (ent_code_q),
      .hi_code   (hi_code_q),
      .lo_code   (lo_code_q),
      .ring_mask (ring_mask),
      .ent_words (ent_words),
      .cap       (cap),
      .hi_thr    (hi_thr),
      .lo_thr    (lo_thr)
   );

   // push wins when both strobes are present
   always_comb begin
      ready    = ~busy;
      push_try = ~busy & push_req & ~cfg_load;
      pop_try  = ~busy & pop_req & ~push_req & ~cfg_load;
   end

   qc_occupancy #(
      .PTR_W(PTR_W), .BLK_LOG2(BLK_LOG2), .RING_W(RING_W)
   ) u_occ (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (cfg_load),
      .ld_rd        (cfg_word[RD_LSB +: PTR_W]),
      .ld_wr        (cfg_word[WR_LSB +: PTR_W]),
      .ld_ring_code (cfg_word[RING_LSB +: RING_W]),
      .ld_ent_code  (cfg_word[ENT_LSB +: 2]),
      .push_try     (push_try),
      .pop_try      (pop_try),
      .ring_mask    (ring_mask),
      .ent_words    (ent_words),
      .cap          (cap),
      .hi_thr       (hi_thr),
      .lo_thr       (lo_thr),
      .rd_ptr       (rd_ptr),
      .wr_ptr       (wr_ptr),
      .acc_push     (acc_push),
      .acc_pop      (acc_pop),
      .empty        (empty),
      .full         (full),
      .near_empty   (nearly_empty),
      .near_full    (nearly_full),
      .err_ovf      (err_overflow),
      .err_udf      (err_underflow)
   );

   qc_word_seq #(
      .PTR_W(PTR_W), .BASE_W(BASE_W), .BLK_LOG2(BLK_LOG2)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cancel    (cfg_load),
      .start     (acc_push | acc_pop),
      .start_wr  (acc_push),
      .start_off (acc_push ? wr_ptr : rd_ptr),
      .ring_mask (ring_mask),
      .base      (base_q),
      .ent_words (ent_words),
      .busy      (busy),
      .mem_addr  (mem_addr),
      .mem_we    (mem_we),
      .mem_re    (mem_re),
      .word_idx  (word_idx)
   );

   // R6 / R7: a refusal cycle carries no memory access
   p_err_quiet_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (err_overflow || err_underflow) |-> !(mem_we || mem_re));
   // R5: full and empty exclude each other
   p_full_empty_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));
   // R8: an empty queue is always below the low mark
   p_lo_on_empty_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> nearly_empty);
   // R9: a full queue is always above the high mark
   p_hi_on_full_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      full |-> nearly_full);
   // R10: simultaneous strobes on a non-full ready queue yield a write burst
   p_push_wins_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && pop_req && ready && !cfg_load && !full) |=> mem_we);

endmodule

// File: tb/tb_sram_queue_ctrl.sv
module tb_sram_queue_ctrl;

   localparam int MEM_N = 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_load = 1'b0;
   logic [31:0] cfg_word = '0;
   logic        push_req = 1'b0;
   logic        pop_req = 1'b0;
   logic        ready, mem_we, mem_re, empty, full, nearly_empty, nearly_full;
   logic        err_overflow, err_underflow;
   logic [12:0] mem_addr;
   logic [1:0]  word_idx;

   sram_queue_ctrl dut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
      .push_req(push_req), .pop_req(pop_req), .ready(ready),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .word_idx(word_idx),
      .empty(empty), .full(full), .nearly_empty(nearly_empty), .nearly_full(nearly_full),
      .err_overflow(err_overflow), .err_underflow(err_underflow)
   );

   always #5 clk = ~clk;

   int n_run = 0;
   int n_fail = 0;
   int unsigned sram [MEM_N];
   int unsigned exp_q[$];
   int unsigned tok = 1;
   int m_hi = 0, m_lo = 0, m_ring = 0, m_ent = 0, m_base = 0, m_rd = 0, m_wr = 0, m_cnt = 0;

   function automatic int thr_of(input int code);
      return (code == 0) ? 0 : (1 << (code - 1));
   endfunction
   function automatic int ring_of(input int code);
      return 16 << code;
   endfunction
   function automatic int ent_of(input int code);
      return (code == 1) ? 2 : (code == 2) ? 4 : 1;
   endfunction
   function automatic int cap_now();
      return ring_of(m_ring) / ent_of(m_ent);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_flags(input string tag);
      int cap;
      cap = cap_now();
      chk(empty == (m_cnt == 0), {"R5 empty ", tag}, int'(empty), int'(m_cnt == 0));
      chk(full == (m_cnt == cap), {"R5 full ", tag}, int'(full), int'(m_cnt == cap));
      chk(nearly_empty == (m_cnt <= thr_of(m_lo)), {"R8 nearly_empty ", tag},
          int'(nearly_empty), int'(m_cnt <= thr_of(m_lo)));
      chk(nearly_full == ((cap - m_cnt) <= thr_of(m_hi)), {"R9 nearly_full ", tag},
          int'(nearly_full), int'((cap - m_cnt) <= thr_of(m_hi)));
      chk(ready == 1'b1, {"R4 ready ", tag}, int'(ready), 1);
   endtask

   // called at a falling edge; returns at a falling edge
   task automatic load_cfg(input int hi, input int lo, input int ring, input int ent,
                           input int base, input int rd, input int wr);
      int bw, e;
      cfg_word = {3'(hi), 3'(lo), 2'(ring), 2'(ent), 8'(base), 7'(rd), 7'(wr)};
      cfg_load = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cfg_load = 1'b0;
      m_hi = hi; m_lo = lo; m_ring = ring; m_ent = ent; m_base = base;
      bw = ring_of(ring);
      e  = ent_of(ent);
      m_rd  = rd % bw;
      m_wr  = wr % bw;
      m_cnt = ((m_wr - m_rd + bw) % bw) / e;
      exp_q.delete();
      for (int k = 0; k < m_cnt * e; k++) exp_q.push_back(0);
      chk_flags("R11 after load");
   endtask

   // called at a falling edge with ready high; returns at a falling edge
   task automatic do_op(input bit p, input bit q, input string tag);
      bit acc_p, acc_q, eov, eun;
      int e, bw, start, exp_addr;
      int unsigned t;
      e  = ent_of(m_ent);
      bw = ring_of(m_ring);
      acc_p = p && (m_cnt != cap_now());
      acc_q = !p && q && (m_cnt != 0);
      eov = p && !acc_p;
      eun = !p && q && !acc_q;
      push_req = p;
      pop_req  = q;
      @(posedge clk);
      @(negedge clk);
      push_req = 1'b0;
      pop_req  = 1'b0;
      chk(err_overflow == eov, {"R6 overflow pulse ", tag}, int'(err_overflow), int'(eov));
      chk(err_underflow == eun, {"R7 underflow pulse ", tag}, int'(err_underflow), int'(eun));
      if (acc_p || acc_q) begin
         start = acc_p ? m_wr : m_rd;
         if (acc_p) begin
            m_wr = (m_wr + e) % bw;
            m_cnt++;
         end else begin
            m_rd = (m_rd + e) % bw;
            m_cnt--;
         end
         for (int i = 0; i < e; i++) begin
            exp_addr = m_base * 16 + ((start + i) % bw);
            chk(int'(mem_addr) == exp_addr, {"R3 address ", tag}, int'(mem_addr), exp_addr);
            chk(mem_we == acc_p && mem_re == acc_q, {"R10 access kind ", tag},
                int'({mem_we, mem_re}), int'({acc_p, acc_q}));
            chk(int'(word_idx) == i, {"R2 word index ", tag}, int'(word_idx), i);
            chk(ready == 1'b0, {"R4 busy ", tag}, int'(ready), 0);
            if (int'(mem_addr) < MEM_N) begin
               if (acc_p) begin
                  sram[mem_addr] = tok;
                  exp_q.push_back(tok);
                  tok++;
               end else if (exp_q.size() > 0) begin
                  t = exp_q.pop_front();
                  if (t != 0)
                     chk(sram[mem_addr] == t, {"R3 data order ", tag},
                         int'(sram[mem_addr]), int'(t));
               end
            end
            @(posedge clk);
            @(negedge clk);
         end
      end else begin
         chk(!mem_we && !mem_re, {"R6 R7 no access ", tag}, int'({mem_we, mem_re}), 0);
      end
      chk_flags(tag);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R4 watchdog: actual 150000 cycles expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : stim
      int ring, ent, hi, lo, base, e, bw, rd, wr, bias;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      chk(empty == 1'b1, "R12 empty", int'(empty), 1);
      chk(full == 1'b0, "R12 full", int'(full), 0);
      chk(nearly_empty == 1'b1, "R12 nearly_empty", int'(nearly_empty), 1);
      chk(nearly_full == 1'b0, "R12 nearly_full", int'(nearly_full), 0);
      chk(ready == 1'b1, "R12 ready", int'(ready), 1);
      chk(!mem_we && !mem_re, "R12 no access", int'({mem_we, mem_re}), 0);
      chk(!err_overflow && !err_underflow, "R12 no error",
          int'({err_overflow, err_underflow}), 0);

      do_op(1'b0, 1'b1, "R7 pop after reset");

      // 16-word ring, aliased entry code -> 1 word (R1, R2)
      load_cfg(2, 1, 0, 3, 5, 0, 0);
      for (int k = 0; k < 16; k++) do_op(1'b1, 1'b0, "R1 fill");
      chk(full == 1'b1, "R1 full at 16 words", int'(full), 1);
      do_op(1'b1, 1'b0, "R6 push when full");
      do_op(1'b1, 1'b1, "R10 both when full");
      do_op(1'b0, 1'b1, "R4 single pop");
      do_op(1'b1, 1'b1, "R10 both when not full");
      for (int k = 0; k < 16; k++) do_op(1'b0, 1'b1, "R1 drain across wrap");
      do_op(1'b0, 1'b1, "R7 pop when empty");

      // load with offsets 4 and 12, 2-word entries in a 32-word ring -> 4 entries (R11)
      load_cfg(6, 3, 1, 1, 7, 4, 12);
      chk(m_cnt == 4, "R11 derived occupancy", m_cnt, 4);
      for (int k = 0; k < 4; k++) do_op(1'b0, 1'b1, "R11 pop loaded entries");
      do_op(1'b0, 1'b1, "R11 R7 empty after loaded entries");

      // 128-word ring of 4-word entries (R1, R2)
      load_cfg(5, 4, 3, 2, 9, 0, 0);
      for (int k = 0; k < 32; k++) do_op(1'b1, 1'b0, "R2 four-word fill");
      do_op(1'b1, 1'b0, "R6 four-word full");
      for (int k = 0; k < 12; k++) do_op(1'b0, 1'b1, "R2 four-word pop");

      // constrained random phase
      for (int c = 0; c < 6; c++) begin
         ring = int'($urandom % 4);
         ent  = int'($urandom % 4);
         bw   = ring_of(ring);
         e    = ent_of(ent);
         hi   = int'($urandom % 8);
         while (thr_of(hi) >= bw / e) hi = int'($urandom % 8);
         lo   = int'($urandom % 8);
         while (thr_of(lo) >= bw / e) lo = int'($urandom % 8);
         base = 4 + int'($urandom % 20);
         rd   = (int'($urandom % bw) / e) * e;
         wr   = (int'($urandom % bw) / e) * e;
         load_cfg(hi, lo, ring, ent, base, rd, wr);
         for (int k = 0; k < 160; k++) begin
            bias = (k < 60) ? 70 : (k < 110) ? 30 : 50;
            do_op(int'($urandom % 100) < bias, ($urandom % 2) == 0, "random");
         end
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule